// File: doc/BRIEF.md
# Strobed Nibble Register Loader

This block is the parallel programming port of a clock synthesizer. A host drives a 4-bit bus and a single STROBE line. A falling STROBE edge latches a register address from the bus, and the next rising edge latches a data nibble for that address. The nibble goes into a bank of sixteen 4-bit control locations. STROBE is asynchronous to the block, so it passes through a synchronizer, and both of its edges are detected in the system clock domain.

After reset, the control image seen by the rest of the chip stays at fixed power-on defaults until 32 writes have been accepted. The defaults select divide-by-four for the load divider and route the reference to the clock output. From the 32nd write on, the image follows the stored contents directly, and each later write is visible as soon as it is stored.

A phase-detector disable output lets the bus's top bit act as a live control line. This needs the enable bit set and the most recently latched address to be 15.

Top module: `nibble_prog_port`

## Requirements
- R1: A falling edge on `strobe_i` latches `ad_i` as the pending address. The bus must be stable from 2 clock cycles before the edge until 6 cycles after it.
- R2: The next rising edge on `strobe_i` latches `ad_i` as data. The data is written to the pending address. Every rising edge counts as exactly one write.
- R3: Until the 32nd write, `ctrl_o` equals the default image. In that image, location 5 holds 0x1 (the load-divider code for divide-by-four), location 12 holds 0x8 (bit 3 routes the reference to the clock output), and every other location holds 0x0.
- R4: The 32nd write makes the full stored contents visible on `ctrl_o`, including the data of that write.
- R5: After unlock, every write appears on `ctrl_o` no more than 4 clock cycles after its rising STROBE edge.
- R6: The write count saturates. Once the block is unlocked it stays unlocked until reset.
- R7: Locations 13 and 14 have no storage and always read 0x0. Writes to them still count toward the 32.
- R8: Location 10 stores and returns its nibble like any other location.
- R9: `pd_disable_o` is high exactly when bit 3 of visible location 15 is 1, the last latched address is 15, and `ad_i[3]` is 1. It follows `ad_i[3]` without a clock delay.
- R10: Reset clears the write count, the stored contents and the last latched address. Location `i` sits at `ctrl_o[4*i+3:4*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_i | input | 4 | Multiplexed address/data bus |
| strobe_i | input | 1 | Asynchronous strobe; idles high |
| ctrl_o | output | 64 | Visible control image, 16 nibbles |
| pd_disable_o | output | 1 | Phase-detector disable |

## Verification
The bench builds the block with its default parameters: a 32-write unlock threshold and a two-flop synchronizer. With these values the whole locked phase, the exact unlock write and the saturated state can all be reached in a short run. Random addresses and data, including the storage-less holes and the spare location, are mixed with directed sequences for the phase-detector gating. A mid-run reset shows that locking starts again from zero.

// File: rtl/nibble_prog_pkg.sv
`timescale 1ns/1ps
// Package: widths and the power-on control image of the nibble loader.
// Assumes address and data nibbles have equal width.
package nibble_prog_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 4;
    localparam int NUM_LOC  = 1 << ADDR_W;
    localparam int IMG_W    = NUM_LOC * DATA_W;
    localparam int LOADDIV_LOC = 5;
    localparam logic [DATA_W-1:0] LOADDIV_DEF = 4'h1;
    localparam int REFSEL_LOC = 12;
    localparam int REFSEL_BIT = 3;
    localparam int PDEN_LOC   = 15;
    localparam int PDEN_BIT   = 3;
    localparam int HOLE_LO    = 13;
    localparam int HOLE_HI    = 14;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] nib_t;

    // Builds the image shown before unlock.
    function automatic logic [IMG_W-1:0] default_image();
        logic [IMG_W-1:0] img;
        img = '0;
        img[LOADDIV_LOC*DATA_W +: DATA_W] = LOADDIV_DEF;
        img[REFSEL_LOC*DATA_W + REFSEL_BIT] = 1'b1;
        return img;
    endfunction
endpackage

// File: rtl/strobe_edge_sync.sv
`timescale 1ns/1ps
// Synchronizes the asynchronous strobe and reports single-cycle rise/fall pulses.
// Assumes the strobe idles high, so reset loads ones to avoid a false fall.
module strobe_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] chain_q;

    // Shift the strobe through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], strobe_i};
    end

    assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    p_fall_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/nibble_capture.sv
`timescale 1ns/1ps
// Latches the address on a fall and the data on a rise, issuing one write pulse.
// Assumes the bus is stable around each detected edge.
module nibble_capture
    import nibble_prog_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t ad_i,
    input  logic  rise_i,
    input  logic  fall_i,
    output logic  wr_o,
    output addr_t wr_addr_o,
    output nib_t  wr_data_o,
    output addr_t last_addr_o
);
    addr_t addr_q;

    // Hold the most recently latched address.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (fall_i) addr_q <= ad_i;
    end

    // Register one write request per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_o      <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_o <= rise_i;
            if (rise_i) begin
                wr_addr_o <= addr_q;
                wr_data_o <= ad_i;
            end
        end
    end

    assign last_addr_o = addr_q;

    p_addr_follows_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> addr_q == $past(ad_i));
endmodule

// File: rtl/nibble_bank.sv
`timescale 1ns/1ps
// Sixteen nibble locations; the hole range has no storage and reads zero.
// Assumes at most one write per cycle.
module nibble_bank
    import nibble_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  addr_t            wr_addr_i,
    input  nib_t             wr_data_i,
    output logic [IMG_W-1:0] live_o
);
    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
        if (i >= HOLE_LO && i <= HOLE_HI) begin : g_hole
            assign live_o[i*DATA_W +: DATA_W] = '0;
        end else begin : g_store
            nib_t q;
            // Store the nibble when this location is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else if (wr_i && wr_addr_i == addr_t'(i)) q <= wr_data_i;
            end
            assign live_o[i*DATA_W +: DATA_W] = q;
        end
    end

    p_hole_write_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_addr_i >= addr_t'(HOLE_LO) && wr_addr_i <= addr_t'(HOLE_HI))
        |=> $stable(live_o));
endmodule

// File: rtl/unlock_counter.sv
`timescale 1ns/1ps
// Counts accepted writes and saturates at the unlock threshold.
// Assumes only reset may clear the count.
module unlock_counter #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    output logic unlocked_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    logic [CNT_W-1:0] cnt_q;

    // Advance once per write until the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (wr_i && cnt_q != CNT_W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end

    assign unlocked_o = (cnt_q == CNT_W'(LIMIT));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !unlocked_o) |=> cnt_q == $past(cnt_q) + 1'b1);
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT));
    p_stay_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked_o |=> unlocked_o);
endmodule

// File: rtl/nibble_prog_port.sv
`timescale 1ns/1ps
// Top: strobed nibble programming port with power-up unlock and
// phase-detector disable gating. Assumes ad_i is held stable around strobe edges.
module nibble_prog_port
    import nibble_prog_pkg::*;
#(
    parameter int UNLOCK_WRITES = 32,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   ad_i,
    input  logic                strobe_i,
    output logic [IMG_W-1:0]    ctrl_o,
    output logic                pd_disable_o
);
    localparam logic [IMG_W-1:0] DEF_IMG = default_image();

    logic             rise, fall, wr, unlocked;
    addr_t            wr_addr, last_addr;
    nib_t             wr_data;
    logic [IMG_W-1:0] live;

    strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i),
        .rise_o(rise), .fall_o(fall));

    nibble_capture u_cap (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .rise_i(rise), .fall_i(fall),
        .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .last_addr_o(last_addr));

    nibble_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .live_o(live));

    unlock_counter #(.LIMIT(UNLOCK_WRITES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .unlocked_o(unlocked));

    // Visible image: defaults while locked, stored contents once unlocked.
    always_comb ctrl_o = unlocked ? live : DEF_IMG;

    // Live bus bit gated by the enable and the last latched address.
    always_comb pd_disable_o = ctrl_o[PDEN_LOC*DATA_W + PDEN_BIT]
                             & (last_addr == addr_t'(PDEN_LOC))
                             & ad_i[ADDR_W-1];

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && $past(!unlocked)) |-> $stable(ctrl_o));
    p_pd_needs_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_disable_o |-> (unlocked && last_addr == addr_t'(PDEN_LOC)));
endmodule

// File: tb/test_nibble_prog_port.sv
`timescale 1ns/1ps
module test_nibble_prog_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ad = 4'h0;
    logic        strobe = 1'b1;
    logic [63:0] ctrl;
    logic        pd;

    int checks = 0;
    int fails  = 0;
    logic [3:0] mem [16];
    int wcount = 0;

    always #2.5 clk = ~clk;

    nibble_prog_port i_nibble_prog_port (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .strobe_i(strobe),
        .ctrl_o(ctrl), .pd_disable_o(pd));

    function automatic logic [63:0] def_img();
        logic [63:0] v = '0;
        v[5*4 +: 4] = 4'h1;
        v[12*4 + 3] = 1'b1;
        return v;
    endfunction

    function automatic logic [63:0] exp_img();
        logic [63:0] v = '0;
        if (wcount < 32) return def_img();
        for (int i = 0; i < 16; i++)
            if (i != 13 && i != 14) v[i*4 +: 4] = mem[i];
        return v;
    endfunction

    task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: ctrl act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pd act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; strobe = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mem[i] = 4'h0;
        wcount = 0;
        @(negedge clk);
    endtask

    // Address phase only: leaves strobe low with address latched.
    task automatic addr_phase(logic [3:0] a);
        @(negedge clk); ad = a;
        repeat (2) @(negedge clk); strobe = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic data_phase(logic [3:0] a, logic [3:0] d);
        ad = d;
        repeat (2) @(negedge clk); strobe = 1'b1;
        repeat (6) @(negedge clk);
        if (a != 13 && a != 14) mem[a] = d;
        if (wcount < 32) wcount++;
    endtask

    task automatic wr(logic [3:0] a, logic [3:0] d);
        addr_phase(a);
        data_phase(a, d);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int seed = 1562;
        void'($urandom(seed));
        do_reset();
        chk64("R10 reset image", ctrl, def_img());
        chk1("R9 pd low at reset", pd, 1'b0);

        // Locked phase: 31 writes, including holes and location 10.
        wr(4'd10, 4'h9); wr(4'd13, 4'hF); wr(4'd14, 4'hE); wr(4'd5, 4'h7);
        chk64("R3 defaults held after early writes", ctrl, def_img());
        for (int k = 4; k < 31; k++) begin
            logic [3:0] a = 4'($urandom());
            if (a == 4'd10) a = 4'd3;
            wr(a, 4'($urandom()));
            if (k % 9 == 0) chk64("R3 defaults while locked", ctrl, def_img());
        end
        chk64("R3 defaults after 31 writes", ctrl, def_img());

        // 32nd write: to a hole, still counts (R7), unlocks (R4).
        wr(4'd13, 4'h5);
        chk64("R4 R7 unlock on 32nd write", ctrl, exp_img());
        chk1("R7 hole 13 reads zero", ctrl[13*4 +: 4] == 4'h0, 1'b1);
        chk1("R8 location 10 kept", ctrl[10*4 +: 4] == 4'h9, 1'b1);

        // R5: transparent writes, check timing at rise + 4 cycles.
        addr_phase(4'd2);
        ad = 4'hA;
        repeat (2) @(negedge clk); strobe = 1'b1;
        repeat (4) @(negedge clk);
        mem[2] = 4'hA;
        chk64("R5 write visible within 4 cycles", ctrl, exp_img());
        repeat (2) @(negedge clk);

        for (int k = 0; k < 30; k++) begin
            logic [3:0] a = 4'($urandom());
            if (a == 4'd15) a = 4'd0;
            wr(a, 4'($urandom()));
            chk64("R2 R6 random write after unlock", ctrl, exp_img());
        end
        wr(4'd10, 4'h3);
        chk64("R8 location 10 rewrite", ctrl, exp_img());
        wr(4'd14, 4'hC);
        chk64("R7 hole 14 ignored", ctrl, exp_img());

        // R9: phase-detector disable gating.
        wr(4'd15, 4'h8);
        ad = 4'h8; @(negedge clk);
        chk1("R9 last address 15, AD3 high", pd, 1'b1);
        ad = 4'h7; #1;
        chk1("R9 AD3 low", pd, 1'b0);
        ad = 4'hF; #1;
        chk1("R9 follows AD3 without clock", pd, 1'b1);
        wr(4'd3, 4'h1);
        ad = 4'h8; @(negedge clk);
        chk1("R9 last address not 15", pd, 1'b0);
        wr(4'd15, 4'h7);
        ad = 4'h8; @(negedge clk);
        chk1("R9 enable bit clear", pd, 1'b0);
        addr_phase(4'd15);
        chk1("R1 address phase only, enable clear", pd, 1'b0);
        data_phase(4'd15, 4'hB);
        chk1("R1 R9 enable set, bus high", pd, 1'b1);

        // R10/R6: reset returns to locked state, count restarts.
        do_reset();
        chk64("R10 reset restores defaults", ctrl, def_img());
        chk1("R10 pd low after reset", pd, 1'b0);
        wr(4'd1, 4'h4);
        chk64("R6 count restarted after reset", ctrl, def_img());

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule